// File: doc/BRIEF.md
# Port-to-Memory Input Sequencer

This block runs one input-and-store transfer for an 8-bit processor core. When the core presents the two-byte trigger opcode together with a start pulse, the block captures three register values: a port number, a byte counter and a 16-bit memory pointer. It reads one byte from the I/O space and then writes that byte to memory at the pointer. The port address it drives carries the counter in its upper half and the port number in its lower half.

The transfer lasts a fixed 16 clocks, one clock per T-state, in four machine cycles of 4, 5, 3 and 4 T-states. The first two cycles stand for the opcode fetches and leave the bus idle. The third is the port read and the fourth is the memory write. When the transfer ends, the block returns the counter decremented by one, the pointer incremented by one and a new flag byte, and it pulses a done signal. The register file of the core takes those results back. A start that arrives while a transfer is running is dropped.

Top module: `port_input_store`

## Requirements
- R1: During the port-read machine cycle (T-states 10 to 12, counting T1 as the first clock after the start is accepted), `addr[7:0]` equals the captured port number and `addr[15:8]` equals the captured counter. `io_rd` is high during T11 only, and `bus_din` is sampled on the clock edge that ends T11.
- R2: During the memory-write machine cycle (T13 to T16), `addr` equals the captured pointer and `bus_dout` equals the byte sampled in R1. `mem_wr` is high during T14 only.
- R3: At the end of the transfer, `b_out` equals the captured counter minus one and `hl_out` equals the captured pointer plus one.
- R4: In `flags_out`, bit 6 (zero) is 1 exactly when the counter minus one is zero, bit 1 (subtract) is 1, and bit 0 (carry) equals bit 0 of the captured `flags_in`. Bits 7, 4 and 2 are undefined.
- R5: The transfer occupies exactly 16 clocks in machine cycles of 4, 5, 3 and 4 T-states. Outside T10 to T16, `addr` is 0 and both strobes are low.
- R6: `done` is high for exactly the one clock after T16. From that clock on, `b_out`, `hl_out` and `flags_out` hold their values until the next `done`.
- R7: A start pulse that arrives while a transfer is running has no effect on the bus sequence or on the results.
- R8: A start pulse whose opcode bytes are not `op_prefix`=ED and `op_code`=A2 (hex) is ignored: no strobe, no `done`, and the result outputs do not change.
- R9: Both updates wrap. A counter of 01 gives `b_out`=00 with the zero flag set, a counter of 00 gives FF with the zero flag clear, and a pointer of FFFF gives 0000.
- R10: While reset is asserted, `addr`, `io_rd`, `mem_wr`, `done`, `b_out`, `hl_out` and `flags_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a transfer |
| op_prefix | input | 8 | First opcode byte presented with start |
| op_code | input | 8 | Second opcode byte presented with start |
| reg_b | input | 8 | Byte counter, captured at start |
| reg_c | input | 8 | Port number, captured at start |
| reg_hl | input | 16 | Memory pointer, captured at start |
| flags_in | input | 8 | Flag byte, captured at start |
| addr | output | 16 | Bus address |
| io_rd | output | 1 | I/O read strobe |
| mem_wr | output | 1 | Memory write strobe |
| bus_din | input | 8 | Data from the bus |
| bus_dout | output | 8 | Data to the bus |
| done | output | 1 | One-clock completion pulse |
| b_out | output | 8 | Decremented counter |
| hl_out | output | 16 | Incremented pointer |
| flags_out | output | 8 | Resulting flag byte |

## Verification
Two situations are hard to reach from the ports. The first is a second start that lands mid-transfer: the bench raises `start` during the second machine cycle with a valid opcode and scrambled register inputs, then confirms that the bus sequence and the results still follow the first operands. The second is a sampling edge that is off by one clock. To catch it, the bench drives the real port byte on `bus_din` only during T11 and its complement in every other T-state, so a wrong edge shows up as a wrong byte on `bus_dout`. A sweep over all 256 counter values covers the zero-flag boundary and the counter wrap, and a dedicated case covers the pointer wrap.

// File: rtl/pis_pkg.sv
package pis_pkg;
   localparam int FLAG_SIGN = 7;
   localparam int FLAG_ZERO = 6;
   localparam int FLAG_HALF = 4;
   localparam int FLAG_PAR  = 2;
   localparam int FLAG_SUB  = 1;
   localparam int FLAG_CRY  = 0;

   typedef enum logic [1:0] {
      MC_FETCH1 = 2'd0,
      MC_FETCH2 = 2'd1,
      MC_PORT   = 2'd2,
      MC_STORE  = 2'd3
   } mcycle_e;
endpackage

// File: rtl/pis_tstate_seq.sv
module pis_tstate_seq
   import pis_pkg::*;
#(
   parameter int M1_T = 4,
   parameter int M2_T = 5,
   parameter int M3_T = 3,
   parameter int M4_T = 4,
   parameter int CW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   output logic          busy,
   output mcycle_e       mc,
   output logic [CW-1:0] t_in_m,
   output logic          last
);
   localparam int TOTAL = M1_T + M2_T + M3_T + M4_T;
   localparam logic [CW-1:0] END1  = CW'(M1_T);
   localparam logic [CW-1:0] END2  = CW'(M1_T + M2_T);
   localparam logic [CW-1:0] END3  = CW'(M1_T + M2_T + M3_T);
   localparam logic [CW-1:0] FINAL = CW'(TOTAL - 1);

   logic [CW-1:0] tcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else if (!busy) begin
         if (go) begin
            busy <= 1'b1;
            tcnt <= '0;
         end
      end else if (last) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else begin
         tcnt <= tcnt + 1'b1;
      end
   end

   always_comb begin
      if (tcnt < END1) begin
         mc     = MC_FETCH1;
         t_in_m = tcnt;
      end else if (tcnt < END2) begin
         mc     = MC_FETCH2;
         t_in_m = tcnt - END1;
      end else if (tcnt < END3) begin
         mc     = MC_PORT;
         t_in_m = tcnt - END2;
      end else begin
         mc     = MC_STORE;
         t_in_m = tcnt - END3;
      end
   end

   assign last = busy && (tcnt == FINAL);
endmodule

// File: rtl/pis_bus_drive.sv
module pis_bus_drive
   import pis_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CW          = 5,
   parameter int IO_STROBE_T = 1,
   parameter int WR_STROBE_T = 1
) (
   input  logic              busy,
   input  mcycle_e           mc,
   input  logic [CW-1:0]     t_in_m,
   input  logic [DATA_W-1:0] cnt_q,
   input  logic [DATA_W-1:0] port_q,
   input  logic [2*DATA_W-1:0] ptr_q,
   input  logic [DATA_W-1:0] byte_q,
   output logic [2*DATA_W-1:0] addr,
   output logic              io_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] dout
);
   localparam logic [CW-1:0] IO_AT = CW'(IO_STROBE_T);
   localparam logic [CW-1:0] WR_AT = CW'(WR_STROBE_T);

   always_comb begin
      addr = '0;
      dout = '0;
      if (busy) begin
         unique case (mc)
            MC_PORT:  addr = {cnt_q, port_q};
            MC_STORE: begin
               addr = ptr_q;
               dout = byte_q;
            end
            default:  addr = '0;
         endcase
      end
   end

   assign io_rd  = busy && (mc == MC_PORT)  && (t_in_m == IO_AT);
   assign mem_wr = busy && (mc == MC_STORE) && (t_in_m == WR_AT);
endmodule

// File: rtl/pis_reg_update.sv
module pis_reg_update
   import pis_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]   cnt_q,
   input  logic [2*DATA_W-1:0] ptr_q,
   input  logic [7:0]          flags_q,
   output logic [DATA_W-1:0]   cnt_nx,
   output logic [2*DATA_W-1:0] ptr_nx,
   output logic [7:0]          flags_nx
);
   always_comb begin
      cnt_nx   = cnt_q - 1'b1;
      ptr_nx   = ptr_q + 1'b1;
      flags_nx = flags_q;
      flags_nx[FLAG_ZERO] = (cnt_nx == '0);
      flags_nx[FLAG_SUB]  = 1'b1;
      flags_nx[FLAG_CRY]  = flags_q[FLAG_CRY];
   end
endmodule

// File: rtl/port_input_store.sv
module port_input_store
   import pis_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         M1_T        = 4,
   parameter int         M2_T        = 5,
   parameter int         M3_T        = 3,
   parameter int         M4_T        = 4,
   parameter int         IO_STROBE_T = 1,
   parameter int         WR_STROBE_T = 1,
   parameter logic [7:0] TRIG_PREFIX = 8'hED,
   parameter logic [7:0] TRIG_CODE   = 8'hA2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [7:0]          op_prefix,
   input  logic [7:0]          op_code,
   input  logic [DATA_W-1:0]   reg_b,
   input  logic [DATA_W-1:0]   reg_c,
   input  logic [2*DATA_W-1:0] reg_hl,
   input  logic [7:0]          flags_in,
   output logic [2*DATA_W-1:0] addr,
   output logic                io_rd,
   output logic                mem_wr,
   input  logic [DATA_W-1:0]   bus_din,
   output logic [DATA_W-1:0]   bus_dout,
   output logic                done,
   output logic [DATA_W-1:0]   b_out,
   output logic [2*DATA_W-1:0] hl_out,
   output logic [7:0]          flags_out
);
   localparam int TOTAL = M1_T + M2_T + M3_T + M4_T;
   localparam int CW    = $clog2(TOTAL + 1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
      if (IO_STROBE_T < 0 || IO_STROBE_T >= M3_T) begin : g_bad_io
         $error("IO_STROBE_T must fall inside the port cycle");
      end
      if (WR_STROBE_T < 0 || WR_STROBE_T >= M4_T) begin : g_bad_wr
         $error("WR_STROBE_T must fall inside the store cycle");
      end
      if (M1_T < 1 || M2_T < 1) begin : g_bad_fetch
         $error("fetch cycles need at least one T-state");
      end
   endgenerate

   logic                busy;
   logic                last;
   logic                accept;
   mcycle_e             mc;
   logic [CW-1:0]       t_in_m;
   logic [DATA_W-1:0]   cnt_q, port_q, byte_q;
   logic [2*DATA_W-1:0] ptr_q;
   logic [7:0]          flg_q;
   logic [DATA_W-1:0]   cnt_nx;
   logic [2*DATA_W-1:0] ptr_nx;
   logic [7:0]          flg_nx;

   assign accept = start && !busy && (op_prefix == TRIG_PREFIX) && (op_code == TRIG_CODE);

   pis_tstate_seq #(
      .M1_T(M1_T), .M2_T(M2_T), .M3_T(M3_T), .M4_T(M4_T), .CW(CW)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .go(accept),
      .busy(busy), .mc(mc), .t_in_m(t_in_m), .last(last)
   );

   pis_bus_drive #(
      .DATA_W(DATA_W), .CW(CW), .IO_STROBE_T(IO_STROBE_T), .WR_STROBE_T(WR_STROBE_T)
   ) i_bus (
      .busy(busy), .mc(mc), .t_in_m(t_in_m),
      .cnt_q(cnt_q), .port_q(port_q), .ptr_q(ptr_q), .byte_q(byte_q),
      .addr(addr), .io_rd(io_rd), .mem_wr(mem_wr), .dout(bus_dout)
   );

   pis_reg_update #(.DATA_W(DATA_W)) i_upd (
      .cnt_q(cnt_q), .ptr_q(ptr_q), .flags_q(flg_q),
      .cnt_nx(cnt_nx), .ptr_nx(ptr_nx), .flags_nx(flg_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         port_q <= '0;
         ptr_q  <= '0;
         flg_q  <= '0;
         byte_q <= '0;
      end else begin
         if (accept) begin
            cnt_q  <= reg_b;
            port_q <= reg_c;
            ptr_q  <= reg_hl;
            flg_q  <= flags_in;
         end
         if (io_rd) begin
            byte_q <= bus_din;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         b_out     <= '0;
         hl_out    <= '0;
         flags_out <= '0;
      end else begin
         done <= last;
         if (last) begin
            b_out     <= cnt_nx;
            hl_out    <= ptr_nx;
            flags_out <= flg_nx;
         end
      end
   end
endmodule

// File: rtl/pis_check.sv
module pis_check
   import pis_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         TOTAL       = 16,
   parameter logic [7:0] TRIG_PREFIX = 8'hED,
   parameter logic [7:0] TRIG_CODE   = 8'hA2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [7:0]          op_prefix,
   input logic [7:0]          op_code,
   input logic [DATA_W-1:0]   reg_b,
   input logic [DATA_W-1:0]   reg_c,
   input logic [2*DATA_W-1:0] reg_hl,
   input logic [7:0]          flags_in,
   input logic [2*DATA_W-1:0] addr,
   input logic                io_rd,
   input logic                mem_wr,
   input logic [DATA_W-1:0]   bus_din,
   input logic [DATA_W-1:0]   bus_dout,
   input logic                done,
   input logic [DATA_W-1:0]   b_out,
   input logic [2*DATA_W-1:0] hl_out,
   input logic [7:0]          flags_out,
   input logic                busy
);
   logic [DATA_W-1:0]   cap_b, cap_c, cap_byte;
   logic [2*DATA_W-1:0] cap_hl;
   logic [7:0]          cap_f;
   logic [7:0]          span;
   logic                taken;

   assign taken = start && !busy && (op_prefix == TRIG_PREFIX) && (op_code == TRIG_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_b <= '0; cap_c <= '0; cap_hl <= '0; cap_f <= '0;
         cap_byte <= '0; span <= '0;
      end else begin
         if (taken) begin
            cap_b <= reg_b; cap_c <= reg_c; cap_hl <= reg_hl; cap_f <= flags_in;
            span  <= '0;
         end else if (busy) begin
            span <= span + 1'b1;
         end
         if (io_rd) cap_byte <= bus_din;
      end
   end

   AST_PORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      io_rd |-> (addr == {cap_b, cap_c}));                                   // R1
   AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (addr == cap_hl && bus_dout == cap_byte));                  // R2
   AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (b_out == cap_b - 1'b1 && hl_out == cap_hl + 1'b1));          // R3
   AST_FLAG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_out[FLAG_ZERO] == (cap_b == 1) && flags_out[FLAG_SUB]
                && flags_out[FLAG_CRY] == cap_f[FLAG_CRY]));                 // R4
   AST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (span == 8'(TOTAL)));                                         // R5
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({io_rd, mem_wr}));                                            // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                       // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!io_rd && !mem_wr && addr == '0));                          // R8
endmodule

bind port_input_store pis_check #(
   .DATA_W(DATA_W), .TOTAL(TOTAL), .TRIG_PREFIX(TRIG_PREFIX), .TRIG_CODE(TRIG_CODE)
) i_pis_check (
   .clk(clk), .rst_n(rst_n), .start(start), .op_prefix(op_prefix), .op_code(op_code),
   .reg_b(reg_b), .reg_c(reg_c), .reg_hl(reg_hl), .flags_in(flags_in),
   .addr(addr), .io_rd(io_rd), .mem_wr(mem_wr), .bus_din(bus_din), .bus_dout(bus_dout),
   .done(done), .b_out(b_out), .hl_out(hl_out), .flags_out(flags_out), .busy(busy)
);

// File: tb/test_port_input_store.sv
module test_port_input_store;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  op_prefix = '0, op_code = '0;
   logic [7:0]  reg_b = '0, reg_c = '0, flags_in = '0;
   logic [15:0] reg_hl = '0;
   logic [15:0] addr;
   logic        io_rd, mem_wr, done;
   logic [7:0]  bus_din = '0, bus_dout, b_out, flags_out;
   logic [15:0] hl_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   port_input_store i_port_input_store (
      .clk(clk), .rst_n(rst_n), .start(start), .op_prefix(op_prefix), .op_code(op_code),
      .reg_b(reg_b), .reg_c(reg_c), .reg_hl(reg_hl), .flags_in(flags_in),
      .addr(addr), .io_rd(io_rd), .mem_wr(mem_wr), .bus_din(bus_din), .bus_dout(bus_dout),
      .done(done), .b_out(b_out), .hl_out(hl_out), .flags_out(flags_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // One transfer; poke raises a second start during machine cycle 2 (R7).
   task automatic xfer(input logic [7:0] b, input logic [7:0] c, input logic [15:0] hl,
                       input logic [7:0] f, input logic [7:0] pbyte, input bit poke);
      logic [15:0] exp_addr;
      logic [7:0]  eb;
      logic [15:0] ehl;
      string       tag;
      @(negedge clk);
      op_prefix = 8'hED; op_code = 8'hA2;
      reg_b = b; reg_c = c; reg_hl = hl; flags_in = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      reg_b = ~b; reg_c = ~c; reg_hl = ~hl; flags_in = ~f;
      for (int k = 0; k < 16; k++) begin
         if (k >= 9 && k <= 11)       begin exp_addr = {b, c}; tag = "R1"; end
         else if (k >= 12)            begin exp_addr = hl;     tag = "R2"; end
         else                         begin exp_addr = 16'h0;  tag = "R5"; end
         chk(addr == exp_addr, tag, $sformatf("addr T%0d", k + 1), 32'(addr), 32'(exp_addr));
         chk(io_rd == (k == 10) && mem_wr == (k == 13) && !done, tag,
             $sformatf("strobes io/wr/done T%0d", k + 1),
             {29'd0, io_rd, mem_wr, done}, {29'd0, k == 10, k == 13, 1'b0});
         if (k == 13)
            chk(bus_dout == pbyte, "R2", "store data", 32'(bus_dout), 32'(pbyte));
         bus_din = (k == 10) ? pbyte : ~pbyte;
         start   = poke && (k == 4);
         @(negedge clk);
      end
      start = 1'b0;
      eb  = b - 8'd1;
      ehl = hl + 16'd1;
      chk(done, "R6", "done after T16", 32'(done), 32'd1);
      chk(b_out == eb, (b == 8'h01 || b == 8'h00) ? "R9" : "R3", "b_out", 32'(b_out), 32'(eb));
      chk(hl_out == ehl, (hl == 16'hFFFF) ? "R9" : "R3", "hl_out", 32'(hl_out), 32'(ehl));
      chk(flags_out[6] == (eb == 8'h00), "R4", "zero flag", 32'(flags_out[6]), 32'(eb == 8'h00));
      chk(flags_out[1] && flags_out[0] == f[0], "R4", "sub/carry flags",
          {30'd0, flags_out[1], flags_out[0]}, {30'd0, 1'b1, f[0]});
      @(negedge clk);
      chk(!done && b_out == eb && hl_out == ehl, poke ? "R7" : "R6", "done drop / hold",
          {7'd0, done, b_out, hl_out}, {8'd0, eb, ehl});
   endtask

   task automatic bad_trigger(input logic [7:0] pre, input logic [7:0] code);
      logic [7:0]  hb;
      logic [15:0] hhl;
      logic [7:0]  hf;
      hb = b_out; hhl = hl_out; hf = flags_out;
      @(negedge clk);
      op_prefix = pre; op_code = code; reg_b = 8'h33; reg_hl = 16'h4444; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 20; k++) begin
         chk(!io_rd && !mem_wr && !done && addr == 16'h0, "R8", "quiet bus",
             {13'd0, io_rd, mem_wr, done, addr}, 32'd0);
         @(negedge clk);
      end
      chk(b_out == hb && hl_out == hhl && flags_out == hf, "R8", "results unchanged",
          {b_out, hl_out, flags_out}, {hb, hhl, hf});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(addr == 0 && !io_rd && !mem_wr && !done, "R10", "bus in reset",
          {13'd0, io_rd, mem_wr, done, addr}, 32'd0);
      chk(b_out == 0 && hl_out == 0 && flags_out == 0, "R10", "results in reset",
          {b_out, hl_out, flags_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // Worked example: port 07, counter 10, pointer 1000, port byte 7B.
      xfer(8'h10, 8'h07, 16'h1000, 8'h00, 8'h7B, 1'b0);
      xfer(8'h01, 8'h80, 16'hFFFF, 8'h01, 8'hA5, 1'b0);   // R9 both wraps
      xfer(8'h00, 8'hFF, 16'h0000, 8'hFE, 8'h00, 1'b0);   // R9 counter wrap
      xfer(8'h22, 8'h11, 16'h2000, 8'hFF, 8'hC3, 1'b1);   // R7
      bad_trigger(8'hED, 8'hA3);
      bad_trigger(8'hCB, 8'hA2);
      for (int i = 0; i < 256; i++) begin
         xfer(8'(i), 8'(i * 37 + 5), {8'(i) ^ 8'hC3, 8'(i * 7)}, 8'(i), 8'(i * 3 + 1),
              (i % 16) == 3);
      end
      finish_run();
   end
endmodule